// File: doc/BRIEF.md
# Half-Width DDR Output Formatter

This block sits between a converter core and the output pins. Each rising edge of the sample clock it takes one 14-bit conversion result, held in offset binary. It recodes the result into the selected number format and delays it by a fixed number of sample clocks. It then presents the word on the output bus, together with a forwarded data clock. The output pins carry ideal digital levels. Electrical drivers lie outside this block.

Two bus modes are available. In single data rate mode the whole word sits on all fourteen bus positions for the full clock period. In double data rate mode only seven lanes carry data, at the even bus positions. During the high half of the forwarded clock, each lane carries the odd bit of its pair. During the low half it carries the even bit. Three codings can be chosen: offset binary, two's complement and Gray.

The mode and coding inputs are captured on the same edge as the sample. They then travel with that word through the pipeline. A change of settings therefore applies from one whole word onward.

Top module: `half_width_formatter`

## Requirements
- R1: While rstN is low, dataOut is all zero and dataClk is low. After reset is released, both stay so until the first captured word reaches the bus.
- R2: A sample captured at the n-th rising edge after reset release is on dataOut from rising edge n+LATENCY onward (LATENCY defaults to 4). dataClk follows clk from rising edge LATENCY+1 onward.
- R3: With the word's mode bit ddrSel=0, dataOut carries the full coded word for the whole clock period.
- R4: With ddrSel=1, lane k is dataOut[2k]. It shows coded bit 2k+1 while dataClk is high and coded bit 2k while dataClk is low.
- R5: With ddrSel=1, the unused bus positions dataOut[2k+1] are driven to zero in both halves of the period.
- R6: codeSel=2'b00 gives offset binary, the input unchanged. The reserved value 2'b11 behaves the same way.
- R7: codeSel=2'b01 gives two's complement: bit 13 of the input is inverted and the other bits pass unchanged. Inputs that rise by one give outputs that rise by one modulo 2^14.
- R8: codeSel=2'b10 gives Gray code. Bit 13 passes through, and bit i is input bit i+1 XOR input bit i. Inputs that rise by one give outputs that differ in exactly one bit.
- R9: ddrSel and codeSel are sampled on the same edge as the sample. Each word on the bus uses only its own settings, even when the settings change on every sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one conversion result per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 14 | Conversion result in offset binary |
| ddrSel | input | 1 | 1 selects half-width double data rate, 0 full-width single data rate |
| codeSel | input | 2 | Output coding: 00 offset binary, 01 two's complement, 10 Gray, 11 offset binary |
| dataOut | output | 14 | Output bus; in DDR mode only the even positions carry data |
| dataClk | output | 1 | Forwarded data clock, low until the pipeline has filled |

## Verification
The pipeline carries each word's mode flag next to its data. A flag that slips by one stage shows on the very next word after a mode change as a bus pattern in the wrong layout. The bench changes the mode and coding between neighbouring words, so that slip is caught at the first transition. A fill counter that is off by one moves the first rising edge of dataClk relative to the first real word. That shows within LATENCY+1 cycles after reset. Swapped lane phases or a miscoded bit show in the first DDR word whose odd and even bits differ.

// File: rtl/fmt_out_pkg.sv
package fmt_out_pkg;

  // Output number coding, selected per sample
  typedef enum logic [1:0] {
    CODE_OFFSET = 2'b00,
    CODE_TWOS   = 2'b01,
    CODE_GRAY   = 2'b10,
    CODE_RSVD   = 2'b11
  } code_e;

  // Strobes handed from control to datapath once per sample clock
  typedef struct packed {
    logic  ddr;       // mode captured with the current sample
    code_e code;      // coding captured with the current sample
    logic  fillDone;  // first real word has reached the output stage
  } ctl_strobe_t;

endpackage

// File: rtl/fmt_out_ctrl.sv
module fmt_out_ctrl
  import fmt_out_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ddrSel,
  input  logic [1:0]  codeSel,
  output ctl_strobe_t strobes
);

  localparam int CNT_W = $clog2(LATENCY + 2);
  localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(LATENCY);

  logic [CNT_W-1:0] fillCnt;
  logic             ddrQ;
  code_e            codeQ;
  logic             fillQ;

  // Settings are sampled on the same edge as the data word, so both
  // enter the pipeline together and a word never mixes two settings.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ddrQ    <= 1'b0;
      codeQ   <= CODE_OFFSET;
      fillCnt <= '0;
      fillQ   <= 1'b0;
    end else begin
      ddrQ  <= ddrSel;
      codeQ <= code_e'(codeSel);
      if (fillCnt != FILL_LAST) begin
        fillCnt <= fillCnt + 1'b1;
      end
      if (fillCnt == FILL_LAST) begin
        fillQ <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.ddr      = ddrQ;
    strobes.code     = codeQ;
    strobes.fillDone = fillQ;
  end

endmodule

// File: rtl/fmt_out_datapath.sv
module fmt_out_datapath
  import fmt_out_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  ctl_strobe_t       strobes,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataClk
);

  localparam int LANES = DATA_W / 2;
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic [DATA_W-1:0] oddPositions();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 1; i < DATA_W; i += 2) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] ODD_MASK = oddPositions();

  function automatic logic [DATA_W-1:0] encode(input logic [DATA_W-1:0] bin,
                                               input code_e code);
    case (code)
      CODE_TWOS: return bin ^ MSB_MASK;
      CODE_GRAY: return bin ^ (bin >> 1);
      default:   return bin;
    endcase
  endfunction

  logic [DATA_W-1:0] rawQ;
  logic [DATA_W-1:0] encWord;
  logic [DATA_W:0]   stageQ [LATENCY];   // {ddr flag, coded word}
  logic [DATA_W-1:0] outWord;
  logic              outDdr;
  logic [DATA_W-1:0] ddrView;

  // Capture stage: raw sample lines up with the control's captured settings
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawQ <= '0;
    else       rawQ <= sampleIn;
  end

  assign encWord = encode(rawQ, strobes.code);

  // Delay line: each entry carries its own mode flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < LATENCY; s++) stageQ[s] <= '0;
    end else begin
      stageQ[0] <= {strobes.ddr, encWord};
      for (int s = 1; s < LATENCY; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign outDdr  = stageQ[LATENCY-1][DATA_W];
  assign outWord = stageQ[LATENCY-1][DATA_W-1:0];

  // Half-width lanes: odd bit while the clock is high, even bit while low
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign ddrView[2*k]   = clk ? outWord[2*k+1] : outWord[2*k];
    assign ddrView[2*k+1] = 1'b0;
  end

  assign dataOut = outDdr ? ddrView : outWord;
  assign dataClk = clk & strobes.fillDone;

  // R5
  always_comb begin
    if (rstN && outDdr) begin
      odd_lane_quiet_chk: assert ((dataOut & ODD_MASK) == '0);
    end
  end

  // R1
  fill_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.fillDone |-> stageQ[LATENCY-1] == '0);

  // R8
  gray_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.code == CODE_GRAY && $past(strobes.code) == CODE_GRAY &&
     rawQ == DATA_W'($past(rawQ) + 1'b1))
    |-> $countones(encWord ^ $past(encWord)) == 1);

  // R7
  twos_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.code == CODE_TWOS && $past(strobes.code) == CODE_TWOS &&
     rawQ == DATA_W'($past(rawQ) + 1'b1))
    |-> encWord == DATA_W'($past(encWord) + 1'b1));

endmodule

// File: rtl/half_width_formatter.sv
module half_width_formatter
  import fmt_out_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              ddrSel,
  input  logic [1:0]        codeSel,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataClk
);

  ctl_strobe_t strobes;

  fmt_out_ctrl #(
    .LATENCY (LATENCY)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ddrSel  (ddrSel),
    .codeSel (codeSel),
    .strobes (strobes)
  );

  fmt_out_datapath #(
    .DATA_W  (DATA_W),
    .LATENCY (LATENCY)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .strobes  (strobes),
    .dataOut  (dataOut),
    .dataClk  (dataClk)
  );

endmodule

// File: tb/test_half_width_formatter.sv
module test_half_width_formatter;

  localparam int W    = 14;
  localparam int LAT  = 4;
  localparam int NVEC = 16;

  // {ddr, code[1:0], sample[13:0], expected coded word[13:0]}
  localparam logic [30:0] VEC [NVEC] = '{
    {1'b0, 2'b00, 14'h0000, 14'h0000},
    {1'b0, 2'b00, 14'h3FFF, 14'h3FFF},
    {1'b0, 2'b01, 14'h2000, 14'h0000},
    {1'b0, 2'b01, 14'h1FFF, 14'h3FFF},
    {1'b0, 2'b10, 14'h0001, 14'h0001},
    {1'b0, 2'b10, 14'h0002, 14'h0003},
    {1'b0, 2'b10, 14'h0003, 14'h0002},
    {1'b0, 2'b10, 14'h3FFF, 14'h2000},
    {1'b1, 2'b00, 14'h2AAA, 14'h2AAA},
    {1'b1, 2'b00, 14'h1555, 14'h1555},
    {1'b1, 2'b01, 14'h0ABC, 14'h2ABC},
    {1'b1, 2'b10, 14'h2000, 14'h3000},
    {1'b1, 2'b10, 14'h1234, 14'h1B2E},
    {1'b0, 2'b11, 14'h1234, 14'h1234},
    {1'b1, 2'b11, 14'h3C3C, 14'h3C3C},
    {1'b0, 2'b10, 14'h1234, 14'h1B2E}
  };

  logic         clk = 1'b0;
  logic         rstN;
  logic [W-1:0] sampleIn;
  logic         ddrSel;
  logic [1:0]   codeSel;
  logic [W-1:0] dataOut;
  logic         dataClk;

  int    edgeCnt;
  int    checks;
  int    fails;
  bit    done;
  logic [W-1:0] expW [0:127];
  logic         expD [0:127];
  string        expTag [0:127];

  always #2 clk = ~clk;

  half_width_formatter #(.DATA_W(W), .LATENCY(LAT)) i_half_width_formatter (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .ddrSel   (ddrSel),
    .codeSel  (codeSel),
    .dataOut  (dataOut),
    .dataClk  (dataClk)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] phaseView(input logic [W-1:0] w,
                                             input logic d, input bit hi);
    logic [W-1:0] r;
    if (!d) return w;
    r = '0;
    for (int k = 0; k < W/2; k++) r[2*k] = hi ? w[2*k+1] : w[2*k];
    return r;
  endfunction

  task automatic checkPhase(input bit hi);
    int idx;
    logic [W-1:0] exp;
    idx = edgeCnt - LAT;
    if (idx >= 1) begin
      exp = phaseView(expW[idx], expD[idx], hi);
      check(dataOut == exp, $sformatf("%s R2 %s", expTag[idx], hi ? "high" : "low"),
            dataOut, exp);
      check(dataClk == hi, "R2 forwarded clock", {13'd0, dataClk}, {13'd0, hi});
      if (expD[idx])
        check((dataOut & 14'h2AAA) == '0, "R5 unused positions",
              dataOut & 14'h2AAA, '0);
    end else begin
      check(dataOut == '0, "R1 bus zero while filling", dataOut, '0);
      check(dataClk == 1'b0, "R1 clock quiet while filling", {13'd0, dataClk}, '0);
    end
  endtask

  task automatic cycle(input logic d, input logic [1:0] c, input logic [W-1:0] s,
                       input logic [W-1:0] e, input string tag);
    ddrSel = d; codeSel = c; sampleIn = s;
    expW[edgeCnt+1] = e; expD[edgeCnt+1] = d; expTag[edgeCnt+1] = tag;
    @(posedge clk); edgeCnt++; #1;
    checkPhase(1'b1);
    @(negedge clk); #1;
    checkPhase(1'b0);
  endtask

  function automatic string vecTag(input int i);
    string t;
    t = VEC[i][30] ? "R4" : "R3";
    case (VEC[i][29:28])
      2'b01:   t = {t, " R7"};
      2'b10:   t = {t, " R8"};
      default: t = {t, " R6"};
    endcase
    if (i > 0 && VEC[i][30:28] != VEC[i-1][30:28]) t = {t, " R9"};
    return t;
  endfunction

  task automatic runTable(input int count);
    for (int i = 0; i < count; i++)
      cycle(VEC[i][30], VEC[i][29:28], VEC[i][27:14], VEC[i][13:0], vecTag(i));
  endtask

  task automatic flush();
    for (int i = 0; i <= LAT; i++)
      cycle(1'b0, 2'b00, '0, '0, "R3 R6 flush");
  endtask

  task automatic resetPhaseCheck();
    check(dataOut == '0, "R1 bus zero in reset", dataOut, '0);
    check(dataClk == 1'b0, "R1 clock low in reset", {13'd0, dataClk}, '0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0; edgeCnt = 0;
    rstN = 1'b0;
    // Inputs active during reset must not reach the bus (R1)
    ddrSel = 1'b1; codeSel = 2'b01; sampleIn = 14'h3FFF;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1; resetPhaseCheck();
      @(negedge clk); #1; resetPhaseCheck();
    end
    rstN = 1'b1;
    edgeCnt = 0;

    // Table of vectors, then drain the pipeline
    runTable(NVEC);
    flush();

    // Reset in mid-stream with words in flight
    runTable(8);
    rstN = 1'b0;
    #1; resetPhaseCheck();
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #1; resetPhaseCheck();
      @(negedge clk); #1; resetPhaseCheck();
    end
    rstN = 1'b1;
    edgeCnt = 0;

    // Refill after reset: first word exactly LATENCY edges later (R2)
    runTable(NVEC);
    flush();

    done = 1;
    summary();
    $finish;
  end

endmodule